// File: doc/BRIEF.md
# Banked Interrupt Request Controller

This block gathers 160 interrupt request lines, arranged as five banks of 32, and turns them into five summary requests toward a processor, one per bank. Bank 0 drives the lowest-numbered processor input and bank 4 the highest. Every line has a pending bit that latches a rising edge of its request, and an enable bit that decides whether that pending bit may raise its bank's summary request. Software reads and writes these registers over a simple synchronous port. It masks a line by clearing its enable bit with a read-modify-write, and it acknowledges a line by writing a one to its pending bit.

A single packed vector register tells the interrupt handler which line to service in every bank at once. Each bank has a 5-bit field in that register. The field holds the lowest-numbered line that is both pending and enabled. The twelve lowest lines of bank 0 carry one shared DMA function. That group has one common enable, one common acknowledge, and one reported index, which is 0.

Reset is asserted asynchronously and released through a two-stage synchronizer. Register writes take effect on the clock edge at which `bus_we` is sampled high. Reads are combinational from `bus_addr`.

Top module: `banked_irq_ctl`

## Requirements
- R1: After reset, every enable bit and every pending bit is 0, `irq_out` is all zero and `irq_vec` is zero.
- R2: The enable register of bank b is at byte address 0x10*b. The pending register of bank b is at 0x10*b+4. The vector register is at 0x80. A write to an enable register replaces it, and the new value reads back.
- R3: A 0-to-1 change on a request line sets that line's pending bit on the next clock edge, whether or not the line is enabled. A request that stays high does not set the bit again.
- R4: Writing a 1 to a pending bit clears it. Writing a 0 leaves it unchanged.
- R5: If a rising edge and a write-1 clear of the same pending bit occur in the same cycle, the bit ends up set.
- R6: `irq_out[b]` is high exactly when some line of bank b is both pending and enabled. A pending line whose enable bit is 0 does not raise the output.
- R7: Bits [5b+4:5b] of the vector give the lowest-numbered pending and enabled line of bank b. The field is 0 when no line of the bank is pending and enabled.
- R8: Bank 0 lines 0 to 11 form one group. Bit 0 of a write to the bank 0 enable register sets or clears all twelve enable bits together, and a read shows that value on bits 0 to 11. Writing a 1 to any of pending bits 0 to 11 of bank 0 clears all twelve.
- R9: When any pending and enabled line of the bank 0 group exists, the bank 0 vector field is 0, even if a higher group line is the lowest pending one.
- R10: Reads of any other address return 0. Writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 160 | Request lines; line i of bank b is bit 32*b+i |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 5 | Per-bank summary request, bank 0 in bit 0 |
| irq_vec | output | 25 | Packed per-bank pending index, bank b in bits [5b+4:5b] |

## Verification
The bench holds a request line high across an acknowledge. A design that treated the request as a level would set the pending bit again and keep the summary request asserted. It drives a new edge in the same cycle as a clear of the same bit; a design where the clear wins would lose that interrupt. Several lines are made pending in one bank with mixed enables, to catch an encoder that picks the highest line, or that ignores the enables and so reports a masked line. The bank 0 group is exercised through its shared enable and acknowledge and its forced index of 0, and writes to unmapped and gap addresses are checked for aliasing onto real registers.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;
  localparam int unsigned DEF_BANKS       = 5;
  localparam int unsigned DEF_LINES       = 32;
  localparam int unsigned DEF_GROUP_LINES = 12;
  localparam int unsigned DEF_ADDR_W      = 8;
  localparam int unsigned BANK_STRIDE     = 16;
  localparam int unsigned OFS_ENABLE      = 0;
  localparam int unsigned OFS_PENDING     = 4;
  localparam int unsigned VEC_OFFSET      = 128;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned LINES   = 32,
  parameter int unsigned GROUP_W = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req,
  input  logic             en_we,
  input  logic             pend_we,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] en_q,
  output logic [LINES-1:0] pend_q
);
  localparam logic [LINES-1:0] GMASK = LINES'((64'(1) << GROUP_W) - 64'(1));

  logic [LINES-1:0] req_q;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] pend_d;
  logic [LINES-1:0] en_d;

  always_comb begin
    rise   = req & ~req_q;
    clr    = '0;
    if (pend_we) begin
      clr = (wdata & ~GMASK) | ({LINES{|(wdata & GMASK)}} & GMASK);
    end
    pend_d = (pend_q & ~clr) | rise;
    en_d   = (wdata & ~GMASK) | ({LINES{wdata[0]}} & GMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
  parameter int unsigned LINES   = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned GROUP_W = 0
) (
  input  logic [LINES-1:0] active,
  output logic [IDX_W-1:0] idx
);
  localparam logic [LINES-1:0] GMASK = LINES'((64'(1) << GROUP_W) - 64'(1));

  always_comb begin
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (active[i]) idx = IDX_W'(i);
    end
    if (|(active & GMASK)) idx = '0;
  end
endmodule

// File: rtl/banked_irq_ctl.sv
module banked_irq_ctl #(
  parameter int unsigned NUM_BANKS   = banked_irq_pkg::DEF_BANKS,
  parameter int unsigned LINES       = banked_irq_pkg::DEF_LINES,
  parameter int unsigned GROUP_LINES = banked_irq_pkg::DEF_GROUP_LINES,
  parameter int unsigned ADDR_W      = banked_irq_pkg::DEF_ADDR_W,
  localparam int unsigned IDX_W      = $clog2(LINES),
  localparam int unsigned VEC_W      = NUM_BANKS * IDX_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS*LINES-1:0] irq_req,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_we,
  input  logic [LINES-1:0]           bus_wdata,
  output logic [LINES-1:0]           bus_rdata,
  output logic [NUM_BANKS-1:0]       irq_out,
  output logic [VEC_W-1:0]           irq_vec
);
  import banked_irq_pkg::*;

  localparam logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(VEC_OFFSET);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NUM_BANKS-1:0][LINES-1:0] en_all;
  logic [NUM_BANKS-1:0][LINES-1:0] st_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(b * BANK_STRIDE + OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(b * BANK_STRIDE + OFS_PENDING);
    localparam int unsigned       GW   = (b == 0) ? GROUP_LINES : 0;

    logic en_we;
    logic st_we;
    assign en_we = bus_we && (bus_addr == A_EN);
    assign st_we = bus_we && (bus_addr == A_ST);

    irq_bank #(.LINES(LINES), .GROUP_W(GW)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .req     (irq_req[b*LINES +: LINES]),
      .en_we   (en_we),
      .pend_we (st_we),
      .wdata   (bus_wdata),
      .en_q    (en_all[b]),
      .pend_q  (st_all[b])
    );

    logic [LINES-1:0] active;
    assign active     = st_all[b] & en_all[b];
    assign irq_out[b] = |active;

    irq_lowest #(.LINES(LINES), .IDX_W(IDX_W), .GROUP_W(GW)) i_enc (
      .active (active),
      .idx    (irq_vec[b*IDX_W +: IDX_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == ADDR_W'(b * BANK_STRIDE + OFS_ENABLE))  bus_rdata = en_all[b];
      if (bus_addr == ADDR_W'(b * BANK_STRIDE + OFS_PENDING)) bus_rdata = st_all[b];
    end
    if (bus_addr == VEC_ADDR) bus_rdata = LINES'(irq_vec);
  end
endmodule

module irq_ctl_checker #(
  parameter int unsigned NUM_BANKS   = 5,
  parameter int unsigned LINES       = 32,
  parameter int unsigned GROUP_LINES = 12,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned IDX_W       = 5
) (
  input logic                            clk,
  input logic                            rst_ni,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic                            bus_we,
  input logic [LINES-1:0]                bus_wdata,
  input logic [NUM_BANKS*LINES-1:0]      irq_req,
  input logic [NUM_BANKS-1:0]            irq_out,
  input logic [NUM_BANKS*IDX_W-1:0]      irq_vec,
  input logic [NUM_BANKS-1:0][LINES-1:0] en_all,
  input logic [NUM_BANKS-1:0][LINES-1:0] st_all
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(b * 16);
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(b * 16 + 4);
    localparam int unsigned       GW   = (b == 0) ? GROUP_LINES : 0;
    localparam logic [LINES-1:0]  GM   = LINES'((64'(1) << GW) - 64'(1));

    logic [IDX_W-1:0] vb;
    logic [LINES-1:0] rq;
    assign vb = irq_vec[b*IDX_W +: IDX_W];
    assign rq = irq_req[b*LINES +: LINES];

    // R2 / R10: enable only changes on a write to its own address
    assert_enable_hold_R2: assert property (@(posedge clk) disable iff (!rst_ni)
      !(bus_we && bus_addr == A_EN) |=> $stable(en_all[b]));

    // R3: pending bits are sticky without a clearing write
    assert_pending_sticky_R3: assert property (@(posedge clk) disable iff (!rst_ni)
      !(bus_we && bus_addr == A_ST) |=> ((st_all[b] & $past(st_all[b])) == $past(st_all[b])));

    // R4: write-1 clears bits whose request is low
    assert_write_one_clears_R4: assert property (@(posedge clk) disable iff (!rst_ni)
      (bus_we && bus_addr == A_ST) |=> ((st_all[b] & $past(bus_wdata & ~rq & ~GM)) == '0));

    // R6: summary request needs an enabled line
    assert_out_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_ni)
      irq_out[b] |-> (en_all[b] != '0));

    // R7: idle bank reports index zero
    assert_vec_idle_R7: assert property (@(posedge clk) disable iff (!rst_ni)
      !irq_out[b] |-> (vb == '0));

    if (b == 0) begin : g_grp
      // R9: active group forces index zero
      assert_group_index_R9: assert property (@(posedge clk) disable iff (!rst_ni)
        (|(st_all[b] & en_all[b] & GM)) |-> (vb == '0));
    end else begin : g_plain
      // R7: reported index names a pending, enabled line
      assert_vec_points_active_R7: assert property (@(posedge clk) disable iff (!rst_ni)
        irq_out[b] |-> (st_all[b][vb] && en_all[b][vb]));
    end
  end
endmodule

bind banked_irq_ctl irq_ctl_checker #(
  .NUM_BANKS(NUM_BANKS), .LINES(LINES), .GROUP_LINES(GROUP_LINES),
  .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) i_chk (
  .clk(clk), .rst_ni(rst_n_int), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .irq_req(irq_req), .irq_out(irq_out),
  .irq_vec(irq_vec), .en_all(en_all), .st_all(st_all)
);

// File: tb/test_banked_irq_ctl.sv
`timescale 1ns/1ps
module test_banked_irq_ctl;
  localparam int NB = 5;
  localparam int L  = 32;

  logic           clk;
  logic           rst_n;
  logic [NB*L-1:0] irq_req;
  logic [7:0]     bus_addr;
  logic           bus_we;
  logic [31:0]    bus_wdata;
  logic [31:0]    bus_rdata;
  logic [NB-1:0]  irq_out;
  logic [24:0]    irq_vec;

  int checks;
  int failures;

  banked_irq_ctl i_banked_irq_ctl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .irq_vec(irq_vec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] a_en(int b); return 8'(b * 16); endfunction
  function automatic logic [7:0] a_st(int b); return 8'(b * 16 + 4); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(int b, int i);
    @(negedge clk);
    irq_req[b*L+i] = 1'b1;
    @(negedge clk);
    irq_req[b*L+i] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin
      rd(a_en(b), d); chk("R1 enable after reset", d, 32'h0);
      rd(a_st(b), d); chk("R1 pending after reset", d, 32'h0);
    end
    chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
    rd(8'h80, d); chk("R1 vector after reset", d, 32'h0);
  endtask

  task automatic t_edge_and_clear;
    logic [31:0] d;
    @(negedge clk); irq_req[2*L+7] = 1'b1;
    repeat (3) @(negedge clk);
    rd(a_st(2), d); chk("R3 edge sets pending while masked", d, 32'h80);
    chk("R6 masked line gives no output", 32'(irq_out), 32'h0);
    wr(a_en(2), 32'h80);
    rd(a_en(2), d); chk("R2 enable readback", d, 32'h80);
    chk("R6 enabled pending raises bank 2", 32'(irq_out), 32'h4);
    rd(8'h80, d); chk("R7 bank 2 field", d, 32'(7) << 10);
    wr(a_st(2), 32'h0);
    rd(a_st(2), d); chk("R4 write zero keeps pending", d, 32'h80);
    wr(a_st(2), 32'h80);
    repeat (2) @(negedge clk);
    rd(a_st(2), d); chk("R3 held-high request does not re-set", d, 32'h0);
    chk("R4 output drops after clear", 32'(irq_out), 32'h0);
    @(negedge clk); irq_req[2*L+7] = 1'b0;
    wr(a_en(2), 32'h0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    wr(a_en(3), (32'h1 << 5) | (32'h1 << 20));
    pulse(3, 20); pulse(3, 9); pulse(3, 5);
    rd(a_st(3), d); chk("R3 three lines pending", d, (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 20));
    rd(8'h80, d); chk("R7 lowest enabled line wins", d, 32'(5) << 15);
    wr(a_en(4), 32'h8000_0000);
    pulse(4, 31);
    rd(8'h80, d); chk("R7 packed fields banks 3 and 4", d, (32'(5) << 15) | (32'(31) << 20));
    chk("R6 two bank outputs", 32'(irq_out), 32'h18);
    wr(a_st(3), 32'h1 << 5);
    rd(8'h80, d); chk("R7 next line after clear, masked 9 skipped", d, (32'(20) << 15) | (32'(31) << 20));
    wr(a_st(3), 32'hFFFF_FFFF);
    wr(a_st(4), 32'hFFFF_FFFF);
    rd(8'h80, d); chk("R7 idle vector is zero", d, 32'h0);
    chk("R4 all outputs low", 32'(irq_out), 32'h0);
    wr(a_en(3), 32'h0); wr(a_en(4), 32'h0);
  endtask

  task automatic t_group;
    logic [31:0] d;
    wr(a_en(0), 32'h1);
    rd(a_en(0), d); chk("R8 bit 0 enables whole group", d, 32'h0000_0FFF);
    wr(a_en(0), 32'h0000_0FFE);
    rd(a_en(0), d); chk("R8 group off when bit 0 is 0", d, 32'h0);
    wr(a_en(0), 32'h0000_8001);
    rd(a_en(0), d); chk("R8 group plus line 15", d, 32'h0000_8FFF);
    pulse(0, 6); pulse(0, 15);
    rd(a_st(0), d); chk("R3 group and plain pending", d, 32'h0000_8040);
    rd(8'h80, d); chk("R9 group reported as index 0", d, 32'h0);
    chk("R6 bank 0 output", 32'(irq_out), 32'h1);
    wr(a_st(0), 32'h1 << 3);
    rd(a_st(0), d); chk("R8 any group bit acknowledges group", d, 32'h0000_8000);
    rd(8'h80, d); chk("R7 bank 0 reports line 15", d, 32'd15);
    wr(a_st(0), 32'h0000_8000);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    pulse(1, 2);
    @(negedge clk);
    irq_req[1*L+2] = 1'b1;
    bus_addr = a_st(1); bus_wdata = 32'h4; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(a_st(1), d); chk("R5 edge beats same-cycle clear", d, 32'h4);
    wr(a_st(1), 32'h4);
    rd(a_st(1), d); chk("R4 later clear succeeds", d, 32'h0);
    @(negedge clk); irq_req[1*L+2] = 1'b0;
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R10 gap read zero", d, 32'h0);
    rd(8'h50, d); chk("R10 bank 5 enable read zero", d, 32'h0);
    rd(8'h84, d); chk("R10 past vector read zero", d, 32'h0);
    rd(a_en(0), d); chk("R10 bank 0 enable untouched", d, 32'h0000_8FFF);
    for (int b = 1; b < NB; b++) begin
      rd(a_en(b), d); chk("R10 other enables untouched", d, 32'h0);
    end
    rd(a_st(0), d); chk("R10 bank 0 pending untouched", d, 32'h0);
    chk("R10 no output after stray writes", 32'(irq_out), 32'h0);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    irq_req = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_edge_and_clear;
    t_priority;
    t_group;
    t_set_wins;
    t_unmapped;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule